// File: doc/BRIEF.md
# Destination Address Exact-Match Filter

This block decides, for every received frame, whether the frame should be kept or dropped based on its 48-bit destination address. The six destination bytes arrive on a byte stream with a start-of-frame marker. Once the sixth byte is taken, the block compares the assembled address against a table of 17 programmable exact-match entries. It also applies a promiscuous override. It then presents a keep/drop decision on a second stream.

The table is written through a simple write-only configuration port. One control word holds the per-entry enables in reversed order: the highest bit enables entry 0. Software normally fills entries from the top, so n active entries occupy enable bits 16 down to 17−n. A typical setup puts the broadcast address in entry 0, the station's own address in entry 1, and multicast groups from entry 2 upward. When the promiscuous bit is set, every frame is kept even if the enable word is zero.

Back-pressure follows valid/ready rules on both streams. A byte moves only in a cycle where `in_valid` and `in_ready` are both high. A decision is consumed in a cycle where `dec_valid` and `dec_ready` are both high. While a decision waits unconsumed, `dec_valid` and `dec_accept` hold steady and `in_ready` is low, so no byte of a following frame is taken. Otherwise `in_ready` is high.

Top module: `dst_addr_filter`

## Requirements
- R1: After reset, `dec_valid` is 0 and `in_ready` is 1. All enables, the promiscuous bit and all entries are 0, so the first frame seen with no configuration is dropped.
- R2: A frame is kept (`dec_accept`=1) when some enabled entry equals all 48 destination bits. The first byte on the stream is the most significant byte of the address.
- R3: Entry k is enabled by bit 16−k of the enable word. An entry whose enable bit is clear never causes a frame to be kept.
- R4: Config address 0 is the enable word, in bits 16:0. Address 1 holds the promiscuous bit in bit 0. Entry k uses addresses 2+2k and 3+2k. The first of these holds address byte 0 in bits 15:8 and byte 1 in bits 7:0. The second holds byte 2 in bits 31:24 down to byte 5 in bits 7:0. A difference in any single byte causes a drop.
- R5: With the promiscuous bit set, every frame is kept, including when the enable word is zero.
- R6: With the promiscuous bit clear and the enable word zero, every frame is dropped.
- R7: `dec_valid` rises in the cycle after the handshake of the sixth address byte. With `dec_ready` high, it stays high for exactly one cycle.
- R8: While `dec_valid` is high and `dec_ready` is low, `dec_valid` and `dec_accept` stay unchanged and `in_ready` is 0.
- R9: A byte with `in_sof`=1 starts a new address at byte 0 and discards any partly collected address. Bytes with `in_sof`=0 that arrive while no address is being collected are ignored and produce no decision.
- R10: Writes to config addresses 2+2·17 and above change neither the enables, the promiscuous bit, nor any entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Address byte present |
| in_ready | output | 1 | Block can take a byte |
| in_data | input | 8 | Address byte |
| in_sof | input | 1 | Byte is address byte 0 of a frame |
| dec_valid | output | 1 | Decision present |
| dec_ready | input | 1 | Consumer takes the decision |
| dec_accept | output | 1 | 1 keep frame, 0 drop frame |
| cfg_we | input | 1 | Config write strobe |
| cfg_addr | input | 6 | Config word address |
| cfg_wdata | input | 32 | Config write data |

## Verification
The bench goes after the reversed enable order. A design that mapped entry k to bit k would keep frames for the wrong entry and drop the intended one. Single-byte corruptions at each of the six positions expose swapped halves or a wrong byte order in the two entry words, which would keep a frame that should be dropped. A stalled decision is held while new start bytes are offered, so a design that let bytes through or changed its answer under back-pressure would be caught. Interrupted addresses, stray bytes with no start marker, and writes past the table check that no extra or corrupted decision appears.

// File: rtl/daf_pkg.sv
package daf_pkg;
  localparam int BYTE_W    = 8;
  localparam int ADDR_BYTES = 6;
  localparam int MAC_W     = BYTE_W * ADDR_BYTES;
  localparam int CFG_DW    = 32;
  typedef logic [MAC_W-1:0] mac_t;
endpackage

// File: rtl/daf_cfg_regs.sv
module daf_cfg_regs
  import daf_pkg::*;
#(
  parameter int N_ENTRIES = 17,
  parameter int CFG_AW = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [CFG_AW-1:0]        cfg_addr,
  input  logic [CFG_DW-1:0]        cfg_wdata,
  output logic [N_ENTRIES-1:0]     en_o,
  output logic                     prom_o,
  output mac_t [N_ENTRIES-1:0]     tbl_o
);
  localparam logic [CFG_AW-1:0] EN_ADDR   = '0;
  localparam logic [CFG_AW-1:0] PROM_ADDR = CFG_AW'(1);
  localparam int LAST_ADDR = 1 + 2 * N_ENTRIES;

  logic unused_wdata_sink;
  assign unused_wdata_sink = ^cfg_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_o   <= '0;
      prom_o <= 1'b0;
    end else if (cfg_we) begin
      if (cfg_addr == EN_ADDR)   en_o   <= cfg_wdata[N_ENTRIES-1:0];
      if (cfg_addr == PROM_ADDR) prom_o <= cfg_wdata[0];
    end
  end

  for (genvar k = 0; k < N_ENTRIES; k++) begin : g_entry
    localparam logic [CFG_AW-1:0] HI_A = CFG_AW'(2 + 2 * k);
    localparam logic [CFG_AW-1:0] LO_A = CFG_AW'(3 + 2 * k);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tbl_o[k] <= '0;
      end else if (cfg_we) begin
        if (cfg_addr == HI_A) tbl_o[k][MAC_W-1:32] <= cfg_wdata[15:0];
        if (cfg_addr == LO_A) tbl_o[k][31:0]       <= cfg_wdata[31:0];
      end
    end
  end

  assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && (int'(cfg_addr) > LAST_ADDR)) |=> ($stable(en_o) && $stable(prom_o) && $stable(tbl_o)));
endmodule

// File: rtl/daf_capture.sv
module daf_capture
  import daf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [BYTE_W-1:0] data,
  input  logic              sof,
  output logic              done_o,
  output mac_t              addr_o
);
  localparam int IDX_W = $clog2(ADDR_BYTES);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ADDR_BYTES - 1);

  logic [MAC_W-BYTE_W-1:0] held_q;
  logic [IDX_W-1:0]        idx_q;
  logic                    busy_q;

  assign done_o = take && !sof && busy_q && (idx_q == LAST_IDX);
  assign addr_o = {held_q, data};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= '0;
      idx_q  <= '0;
      busy_q <= 1'b0;
    end else if (take) begin
      if (sof) begin
        held_q <= {{(MAC_W-2*BYTE_W){1'b0}}, data};
        idx_q  <= IDX_W'(1);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        held_q <= {held_q[MAC_W-2*BYTE_W-1:0], data};
        if (idx_q == LAST_IDX) begin
          idx_q  <= '0;
          busy_q <= 1'b0;
        end else begin
          idx_q <= idx_q + IDX_W'(1);
        end
      end
    end
  end

  assert_idx_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= LAST_IDX);
  assert_idle_idx_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !sof && !busy_q) |=> !busy_q);
endmodule

// File: rtl/daf_match.sv
module daf_match
  import daf_pkg::*;
#(
  parameter int N_ENTRIES = 17
) (
  input  mac_t                 addr,
  input  logic [N_ENTRIES-1:0] en,
  input  mac_t [N_ENTRIES-1:0] tbl,
  output logic                 hit_o
);
  logic [N_ENTRIES-1:0] hit;
  for (genvar k = 0; k < N_ENTRIES; k++) begin : g_cmp
    assign hit[k] = en[N_ENTRIES-1-k] && (tbl[k] == addr);
  end
  assign hit_o = |hit;
endmodule

// File: rtl/dst_addr_filter.sv
module dst_addr_filter
  import daf_pkg::*;
#(
  parameter int N_ENTRIES = 17,
  localparam int CFG_AW = $clog2(2 * N_ENTRIES + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  input  logic              in_sof,
  output logic              dec_valid,
  input  logic              dec_ready,
  output logic              dec_accept,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata
);
  logic [N_ENTRIES-1:0] en;
  logic                 prom;
  mac_t [N_ENTRIES-1:0] tbl;
  mac_t                 cur_addr;
  logic                 addr_done;
  logic                 hit;
  logic                 take;

  assign in_ready = !(dec_valid && !dec_ready);
  assign take     = in_valid && in_ready;

  daf_cfg_regs #(.N_ENTRIES(N_ENTRIES), .CFG_AW(CFG_AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .en_o(en), .prom_o(prom), .tbl_o(tbl)
  );

  daf_capture u_cap (
    .clk(clk), .rst_n(rst_n), .take(take), .data(in_data), .sof(in_sof),
    .done_o(addr_done), .addr_o(cur_addr)
  );

  daf_match #(.N_ENTRIES(N_ENTRIES)) u_match (
    .addr(cur_addr), .en(en), .tbl(tbl), .hit_o(hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_valid  <= 1'b0;
      dec_accept <= 1'b0;
    end else if (addr_done) begin
      dec_valid  <= 1'b1;
      dec_accept <= prom || hit;
    end else if (dec_ready) begin
      dec_valid  <= 1'b0;
    end
  end

  assert_dec_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    addr_done |=> dec_valid);
  assert_no_spurious_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!addr_done && !(dec_valid && !dec_ready)) |=> !dec_valid);
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !dec_ready) |=> (dec_valid && $stable(dec_accept)));
  assert_prom_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_done && prom) |=> dec_accept);
  assert_all_off_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_done && !prom && (en == '0)) |=> !dec_accept);
endmodule

// File: tb/dst_addr_filter_bench.sv
module dst_addr_filter_bench;
  localparam int CLK_PER = 10;
  localparam int N = 17;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_sof = 1'b0, dec_ready = 1'b1;
  logic [7:0] in_data = '0;
  logic in_ready, dec_valid, dec_accept;
  logic cfg_we = 1'b0;
  logic [5:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;

  int total = 0, bad = 0;
  logic [47:0] m_tbl [N];
  logic [N-1:0] m_en = '0;
  logic m_prom = 1'b0;

  always #(CLK_PER/2) clk = ~clk;

  dst_addr_filter u_dst_addr_filter (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sof(in_sof), .dec_valid(dec_valid),
    .dec_ready(dec_ready), .dec_accept(dec_accept), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata)
  );

  task automatic check(input logic cond, input string tag, input int act, input int exp);
    total++;
    if (!cond) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic model_keep(input logic [47:0] a);
    logic r = m_prom;
    for (int k = 0; k < N; k++)
      if (m_en[N-1-k] && m_tbl[k] == a) r = 1'b1;
    return r;
  endfunction

  task automatic cfg_write(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk); #1 cfg_we = 1'b0;
  endtask

  task automatic set_entry(input int k, input logic [47:0] a);
    cfg_write(6'(2 + 2*k), {16'h0, a[47:32]});
    cfg_write(6'(3 + 2*k), a[31:0]);
    m_tbl[k] = a;
  endtask

  task automatic set_en(input logic [N-1:0] e);
    cfg_write(6'd0, 32'(e)); m_en = e;
  endtask

  task automatic set_prom(input logic p);
    cfg_write(6'd1, {31'h0, p}); m_prom = p;
  endtask

  task automatic push_byte(input logic [7:0] b, input logic s);
    @(negedge clk); in_valid = 1'b1; in_sof = s; in_data = b;
    @(posedge clk);
  endtask

  task automatic send_check(input logic [47:0] a, input string tag);
    logic exp = model_keep(a);
    for (int i = 0; i < 6; i++) push_byte(a[47-8*i -: 8], i == 0);
    @(negedge clk); in_valid = 1'b0; in_sof = 1'b0;
    check(dec_valid === 1'b1, "R7 decision one cycle after byte 5", int'(dec_valid), 1);
    check(dec_accept === exp, tag, int'(dec_accept), int'(exp));
    @(negedge clk);
    check(dec_valid === 1'b0, "R7 single pulse", int'(dec_valid), 0);
  endtask

  function automatic logic [N-1:0] contig(input int n);
    logic [N-1:0] m = '0;
    for (int i = 0; i < n; i++) m[N-1-i] = 1'b1;
    return m;
  endfunction

  localparam logic [47:0] BCAST = 48'hFFFF_FFFF_FFFF;
  localparam logic [47:0] STA   = 48'h02A1_B2C3_D4E5;

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [47:0] a;
    void'($urandom(32'd7351));
    for (int k = 0; k < N; k++) m_tbl[k] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(dec_valid === 1'b0, "R1 dec_valid after reset", int'(dec_valid), 0);
    check(in_ready === 1'b1, "R1 in_ready after reset", int'(in_ready), 1);
    send_check(48'h0, "R1 empty table drops zero address");
    send_check(BCAST, "R6 nothing enabled drops broadcast");

    set_entry(0, BCAST);
    set_entry(1, STA);
    for (int k = 2; k < N; k++) set_entry(k, {8'h01, 8'h00, 32'($urandom)} | 48'h0100_0000_0000);
    send_check(STA, "R6 entries written but disabled drop");

    set_en(contig(2));
    send_check(BCAST, "R2 broadcast in entry 0 kept");
    send_check(STA, "R2 station in entry 1 kept");
    send_check(m_tbl[4], "R2 entry 4 not enabled dropped");
    for (int b = 0; b < 6; b++) begin
      a = STA ^ (48'h5A << (8*b));
      send_check(a, $sformatf("R4 byte %0d mismatch dropped", 5-b));
    end

    set_entry(5, 48'h0133_4455_6677);
    set_en(17'(1) << (N-1-5));
    send_check(48'h0133_4455_6677, "R3 entry 5 kept via bit 11");
    set_en(17'(1) << 5);
    send_check(48'h0133_4455_6677, "R3 bit 5 enables entry 11 not entry 5");
    send_check(m_tbl[11], "R3 entry 11 kept via bit 5");

    set_en('0);
    set_prom(1'b1);
    send_check(48'h1234_5678_9ABC, "R5 promiscuous keeps with zero enables");
    set_prom(1'b0);
    send_check(48'h1234_5678_9ABC, "R6 promiscuous off drops");

    set_en(contig(2));
    for (int ad = 2 + 2*N; ad < 64; ad++) cfg_write(6'(ad), 32'hFFFF_FFFF);
    send_check(STA, "R10 station still kept after stray writes");
    send_check(48'h1234_5678_9ABC, "R10 promiscuous still off after stray writes");
    send_check(m_tbl[3], "R10 enables unchanged after stray writes");

    // R9 interrupted address, then full address
    push_byte(8'hAA, 1'b1); push_byte(8'hBB, 1'b0); push_byte(8'hCC, 1'b0);
    @(negedge clk); in_valid = 1'b0;
    check(dec_valid === 1'b0, "R9 partial address no decision", int'(dec_valid), 0);
    send_check(STA, "R9 restart on sof gives correct result");
    for (int i = 0; i < 6; i++) push_byte(STA[47-8*i -: 8], 1'b0);
    @(negedge clk); in_valid = 1'b0;
    check(dec_valid === 1'b0, "R9 bytes without sof ignored", int'(dec_valid), 0);
    @(negedge clk);
    check(dec_valid === 1'b0, "R9 bytes without sof ignored later", int'(dec_valid), 0);

    // R8 back-pressure
    dec_ready = 1'b0;
    for (int i = 0; i < 6; i++) push_byte(BCAST[47-8*i -: 8], i == 0);
    @(negedge clk); in_valid = 1'b1; in_sof = 1'b1; in_data = 8'h02;
    check(dec_valid === 1'b1 && dec_accept === 1'b1, "R8 held decision present",
          int'({dec_valid, dec_accept}), 3);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      check(in_ready === 1'b0, "R8 in_ready low while stalled", int'(in_ready), 0);
      check(dec_valid === 1'b1 && dec_accept === 1'b1, "R8 decision stable while stalled",
            int'({dec_valid, dec_accept}), 3);
    end
    in_valid = 1'b0; in_sof = 1'b0; dec_ready = 1'b1;
    @(negedge clk);
    check(dec_valid === 1'b0, "R8 decision consumed", int'(dec_valid), 0);
    for (int i = 0; i < 5; i++) push_byte(STA[39-8*i -: 8], 1'b0);
    @(negedge clk); in_valid = 1'b0;
    check(dec_valid === 1'b0, "R8 stalled sof byte was not taken", int'(dec_valid), 0);

    // random mix
    for (int it = 0; it < 300; it++) begin
      int sel;
      if ($urandom_range(0, 7) == 0) set_en(contig($urandom_range(0, N)));
      if ($urandom_range(0, 15) == 0) set_prom(~m_prom);
      sel = $urandom_range(0, 3);
      case (sel)
        0: a = {16'($urandom), 32'($urandom)};
        1: a = m_tbl[$urandom_range(0, N-1)];
        2: a = m_tbl[$urandom_range(0, N-1)] ^ (48'h1 << $urandom_range(0, 47));
        default: a = BCAST;
      endcase
      send_check(a, "R2 random address decision");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule